// File: doc/BRIEF.md
# Serial Expander Pin Interrupt Detector

This block watches the input pins of a serial GPIO expander and turns pin activity into interrupts. The deserializer upstream hands it a complete, freshly shifted input vector together with a single-cycle strobe that marks it as new. Each pin can watch for a rising edge, a falling edge, either edge, or a high or low level. The result is kept in a sticky status bit. Software clears that bit by writing a one to it. All pins that are both enabled and flagged are merged into one interrupt line.

Pins are grouped into banks of 32. Each bank has five 32-bit registers, reached through a single-cycle write port and a combinational read port. Both ports address a register by bank index and register select. The pin count is a parameter, and the default is 80 pins in three banks. Register bits that stand above the last implemented pin do not exist.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every enable, type and status bit reads 0 and irq_o is 0.
- R2: With type1=0, type2=0 and type0=0, a pin flags a falling edge. A falling edge means the pin was 1 at the previous strobe and is 0 at this strobe.
- R3: With type1=0, type2=0 and type0=1, a pin flags a rising edge. A rising edge means the pin was 0 at the previous strobe and is 1 at this strobe.
- R4: With type1=0 and type2=1, a pin flags any change between strobes, whatever type0 holds.
- R5: With type1=1, a pin is in level mode, whatever type2 holds. With type0=1 it flags while the pin is 1. With type0=0 it flags while the pin is 0.
- R6: A status bit is raised only in a strobe cycle in which the pin's enable bit is already 1.
- R7: Writing register select 4 (status) clears each bit written as 1. Bits written as 0 keep their value. No other action clears a status bit.
- R8: The register select codes are 0 enable, 1 type0, 2 type1, 3 type2 and 4 status. Pin n lives in bank n>>5 at bit n&31. A bank index with no bank behind it reads 0.
- R9: Detection happens only when sample_vld_i is 1. Edges are judged against the value captured at the previous strobe, and that value is 0 after reset. Activity between strobes is not seen.
- R10: A level-mode status bit that is cleared while the level is still present is set again at the next strobe, and not before it.
- R11: irq_o is 1 exactly when some status bit is 1 whose enable bit is also 1. Clearing an enable masks the line but leaves the status bit set.
- R12: Register bits above pin NUM_PINS-1 always read 0, even after writes of all ones.
- R13: When a status clear and a new detection on the same pin fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | NUM_PINS | Deserialized pin input vector |
| sample_vld_i | input | 1 | One-cycle strobe: sample_i holds a new vector |
| reg_we_i | input | 1 | Register write enable |
| reg_bank_i | input | BANK_W | Bank index for reads and writes |
| reg_sel_i | input | 3 | Register select (0 enable, 1 type0, 2 type1, 3 type2, 4 status) |
| reg_wdata_i | input | LANE_W | Write data |
| reg_rdata_o | output | LANE_W | Read data of the selected register, combinational |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach from the ports is a set and a clear that meet in the same cycle. A level-mode pin must already be flagged, and the write-one-to-clear must land in the very cycle in which the strobe detects the level again. The bench drives both the write and the strobe through a single task, so the two meet on one clock edge. A second hard case is pin activity that comes and goes between strobes. The bench pulses a pin with the strobe held low, then strobes with the original value, and shows that the status bit stays clear.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_TYPE0  = 3'd1,
    SEL_TYPE1  = 3'd2,
    SEL_TYPE2  = 3'd3,
    SEL_STATUS = 3'd4
  } reg_sel_e;

  localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/pin_irq_cell.sv
module pin_irq_cell
  import pin_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     strobe_i,
  input  logic     pin_i,
  input  logic     we_i,
  input  reg_sel_e sel_i,
  input  logic     wbit_i,
  output logic     en_o,
  output logic     t0_o,
  output logic     t1_o,
  output logic     t2_o,
  output logic     st_o
);
  logic en_q, t0_q, t1_q, t2_q, st_q, prev_q;
  logic rise, fall, sensed, hit, clr;

  assign rise = pin_i & ~prev_q;
  assign fall = ~pin_i & prev_q;

  always_comb begin
    if (t1_q)      sensed = t0_q ? pin_i : ~pin_i;  // level mode dominates
    else if (t2_q) sensed = rise | fall;
    else           sensed = t0_q ? rise : fall;
  end

  assign hit = strobe_i & en_q & sensed;
  assign clr = we_i & (sel_i == SEL_STATUS) & wbit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      t0_q   <= 1'b0;
      t1_q   <= 1'b0;
      t2_q   <= 1'b0;
      st_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      if (we_i && sel_i == SEL_ENABLE) en_q <= wbit_i;
      if (we_i && sel_i == SEL_TYPE0)  t0_q <= wbit_i;
      if (we_i && sel_i == SEL_TYPE1)  t1_q <= wbit_i;
      if (we_i && sel_i == SEL_TYPE2)  t2_q <= wbit_i;
      if (strobe_i) prev_q <= pin_i;
      st_q <= (st_q & ~clr) | hit;  // new detection wins over clear
    end
  end

  assign en_o = en_q;
  assign t0_o = t0_q;
  assign t1_o = t1_q;
  assign t2_o = t2_q;
  assign st_o = st_q;
endmodule

// File: rtl/pin_irq_bank.sv
module pin_irq_bank
  import pin_irq_pkg::*;
#(
  parameter int unsigned LANE_W     = 32,
  parameter int unsigned VALID_BITS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [LANE_W-1:0] pins_i,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o,
  output logic [LANE_W-1:0] en_o,
  output logic [LANE_W-1:0] st_o
);
  logic [LANE_W-1:0] t0_v, t1_v, t2_v;

  for (genvar i = 0; i < LANE_W; i++) begin : g_bit
    if (i < VALID_BITS) begin : g_pin
      pin_irq_cell i_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe_i),
        .pin_i    (pins_i[i]),
        .we_i     (we_i),
        .sel_i    (sel_i),
        .wbit_i   (wdata_i[i]),
        .en_o     (en_o[i]),
        .t0_o     (t0_v[i]),
        .t1_o     (t1_v[i]),
        .t2_o     (t2_v[i]),
        .st_o     (st_o[i])
      );
    end else begin : g_absent
      logic unused_bit;
      assign unused_bit = wdata_i[i] ^ pins_i[i];
      assign en_o[i] = 1'b0;
      assign t0_v[i] = 1'b0;
      assign t1_v[i] = 1'b0;
      assign t2_v[i] = 1'b0;
      assign st_o[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_ENABLE: rdata_o = en_o;
      SEL_TYPE0:  rdata_o = t0_v;
      SEL_TYPE1:  rdata_o = t1_v;
      SEL_TYPE2:  rdata_o = t2_v;
      SEL_STATUS: rdata_o = st_o;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 80,
  parameter int unsigned LANE_W    = 32,
  localparam int unsigned NUM_BANKS = (NUM_PINS + LANE_W - 1) / LANE_W,
  localparam int unsigned BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] sample_i,
  input  logic                sample_vld_i,
  input  logic                reg_we_i,
  input  logic [BANK_W-1:0]   reg_bank_i,
  input  logic [SEL_W-1:0]    reg_sel_i,
  input  logic [LANE_W-1:0]   reg_wdata_i,
  output logic [LANE_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  localparam int unsigned TOT_W = NUM_BANKS * LANE_W;

  logic [TOT_W-1:0]  pins_pad;
  logic [TOT_W-1:0]  status_all, enable_all;
  logic [LANE_W-1:0] bank_rdata [NUM_BANKS];
  reg_sel_e          sel;

  assign pins_pad = TOT_W'(sample_i);
  assign sel      = reg_sel_e'(reg_sel_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned REMAIN = NUM_PINS - b * LANE_W;
    localparam int unsigned VB     = (REMAIN >= LANE_W) ? LANE_W : REMAIN;
    logic bank_we;
    assign bank_we = reg_we_i && (reg_bank_i == BANK_W'(b));

    pin_irq_bank #(
      .LANE_W     (LANE_W),
      .VALID_BITS (VB)
    ) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (sample_vld_i),
      .pins_i   (pins_pad[b*LANE_W +: LANE_W]),
      .we_i     (bank_we),
      .sel_i    (sel),
      .wdata_i  (reg_wdata_i),
      .rdata_o  (bank_rdata[b]),
      .en_o     (enable_all[b*LANE_W +: LANE_W]),
      .st_o     (status_all[b*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_bank_i == BANK_W'(b)) reg_rdata_o = bank_rdata[b];
    end
  end

  assign irq_o = |(status_all & enable_all);
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 80,
  parameter int unsigned LANE_W    = 32,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          sample_vld_i,
  input logic                          reg_we_i,
  input logic [BANK_W-1:0]             reg_bank_i,
  input logic [SEL_W-1:0]              reg_sel_i,
  input logic [LANE_W-1:0]             reg_rdata_o,
  input logic                          irq_o,
  input logic [NUM_BANKS*LANE_W-1:0]   status_all,
  input logic [NUM_BANKS*LANE_W-1:0]   enable_all
);
  localparam int unsigned TAIL_BITS = NUM_PINS - (NUM_BANKS - 1) * LANE_W;

  function automatic logic [LANE_W-1:0] tail_mask();
    logic [LANE_W-1:0] m = '0;
    for (int i = 0; i < LANE_W; i++) if (i < TAIL_BITS) m[i] = 1'b1;
    return m;
  endfunction

  assert_irq_needs_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_all == '0) |-> !irq_o);

  assert_irq_needs_status_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_all != '0));

  assert_set_only_on_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> ((status_all & ~$past(status_all)) == '0));

  assert_set_only_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i |=> ((status_all & ~$past(status_all) & ~$past(enable_all)) == '0));

  assert_clear_needs_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_sel_i == SEL_W'(SEL_STATUS)) |=> (($past(status_all) & ~status_all) == '0));

  assert_tail_bits_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_bank_i == BANK_W'(NUM_BANKS - 1)) |-> ((reg_rdata_o & ~tail_mask()) == '0));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(
  .NUM_PINS  (NUM_PINS),
  .LANE_W    (LANE_W),
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W)
) i_pin_irq_ctrl_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_vld_i (sample_vld_i),
  .reg_we_i     (reg_we_i),
  .reg_bank_i   (reg_bank_i),
  .reg_sel_i    (reg_sel_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_o        (irq_o),
  .status_all   (status_all),
  .enable_all   (enable_all)
);

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
  localparam int NP = 80;
  localparam int LW = 32;
  localparam int BW = 2;
  localparam logic [2:0] S_EN = 3'd0, S_T0 = 3'd1, S_T1 = 3'd2, S_T2 = 3'd3, S_ST = 3'd4;

  // {type2, type1, type0, prev, cur, expected}
  localparam logic [5:0] VEC [32] = '{
    6'b000_00_0, 6'b000_01_0, 6'b000_10_1, 6'b000_11_0,
    6'b001_00_0, 6'b001_01_1, 6'b001_10_0, 6'b001_11_0,
    6'b100_00_0, 6'b100_01_1, 6'b100_10_1, 6'b100_11_0,
    6'b101_00_0, 6'b101_01_1, 6'b101_10_1, 6'b101_11_0,
    6'b010_00_1, 6'b010_01_0, 6'b010_10_1, 6'b010_11_0,
    6'b011_00_0, 6'b011_01_1, 6'b011_10_0, 6'b011_11_1,
    6'b110_00_1, 6'b110_01_0, 6'b110_10_1, 6'b110_11_0,
    6'b111_00_0, 6'b111_01_1, 6'b111_10_0, 6'b111_11_1
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] sample_i = '0;
  logic          sample_vld_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [BW-1:0] reg_bank_i = '0;
  logic [2:0]    reg_sel_i = '0;
  logic [LW-1:0] reg_wdata_i = '0;
  logic [LW-1:0] reg_rdata_o;
  logic          irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pin_irq_ctrl #(.NUM_PINS(NP), .LANE_W(LW)) i_pin_irq_ctrl (.*);

  task automatic step();
    @(posedge clk_i); #5;
  endtask

  task automatic wr(input int bank, input logic [2:0] sel, input logic [LW-1:0] d);
    reg_bank_i = BW'(bank); reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1'b1;
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic strobe(input logic [NP-1:0] v);
    sample_i = v; sample_vld_i = 1'b1;
    step();
    sample_vld_i = 1'b0;
  endtask

  task automatic rd(input int bank, input logic [2:0] sel, output logic [LW-1:0] d);
    reg_bank_i = BW'(bank); reg_sel_i = sel;
    #1 d = reg_rdata_o;
  endtask

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; sample_i = '0; sample_vld_i = 1'b0; reg_we_i = 1'b0;
    repeat (2) step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic pin_vec(input int p, input logic v, output logic [NP-1:0] o);
    o = '0; o[p] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] d;
    logic [NP-1:0] v;
    do_reset();
    // R1 reset state
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 5; s++) begin
        rd(b, 3'(s), d); chk("R1 reset regs", d, '0);
      end
    chk("R1 reset irq", LW'(irq_o), '0);

    // table: pin 37 = bank 1 bit 5 (R8)
    for (int k = 0; k < 32; k++) begin
      logic [5:0] e;
      string req;
      e = VEC[k];
      req = e[4] ? "R5 level" : (e[5] ? "R4 both edges" : (e[3] ? "R3 rising" : "R2 falling"));
      wr(1, S_T0, LW'(e[3]) << 5);
      wr(1, S_T1, LW'(e[4]) << 5);
      wr(1, S_T2, LW'(e[5]) << 5);
      wr(1, S_EN, 32'h20);
      pin_vec(37, e[2], v); strobe(v);
      wr(1, S_ST, '1);
      pin_vec(37, e[1], v); strobe(v);
      rd(1, S_ST, d); chk(req, d, LW'(e[0]) << 5);
      chk({req, " irq"}, LW'(irq_o), LW'(e[0]));
      wr(1, S_ST, '1);
    end

    do_reset();
    // R9: edge reference is 0 after reset
    wr(0, S_T0, 32'h1); wr(0, S_EN, 32'h1);
    pin_vec(0, 1'b1, v); strobe(v);
    rd(0, S_ST, d); chk("R9 first strobe rising", d, 32'h1);
    wr(0, S_ST, 32'h1);
    // R6: disabled pin never flags
    wr(0, S_EN, 32'h0);
    pin_vec(0, 1'b0, v); strobe(v);
    pin_vec(0, 1'b1, v); strobe(v);
    rd(0, S_ST, d); chk("R6 disabled no status", d, 32'h0);
    chk("R6 disabled no irq", LW'(irq_o), '0);
    wr(0, S_EN, 32'h1);
    rd(0, S_ST, d); chk("R6 late enable no status", d, 32'h0);
    // R9: activity between strobes ignored
    pin_vec(0, 1'b0, v); strobe(v);
    sample_i[0] = 1'b1; step(); step();
    sample_i[0] = 1'b0; step();
    strobe('0);
    rd(0, S_ST, d); chk("R9 unstrobed pulse", d, 32'h0);
    pin_vec(0, 1'b1, v); strobe(v);
    rd(0, S_ST, d); chk("R3 rising after strobe", d, 32'h1);
    chk("R11 irq on", LW'(irq_o), 1);
    // R7 write-one-to-clear
    wr(0, S_ST, 32'h0);
    rd(0, S_ST, d); chk("R7 zero write keeps", d, 32'h1);
    wr(0, S_ST, 32'h1);
    rd(0, S_ST, d); chk("R7 one write clears", d, 32'h0);
    chk("R7 irq off", LW'(irq_o), 0);
    // R11 enable masks irq only
    strobe('0); pin_vec(0, 1'b1, v); strobe(v);
    wr(0, S_EN, 32'h0);
    chk("R11 masked irq", LW'(irq_o), 0);
    rd(0, S_ST, d); chk("R11 status kept", d, 32'h1);
    wr(0, S_EN, 32'h1);
    chk("R11 unmasked irq", LW'(irq_o), 1);
    wr(0, S_ST, 32'h1);
    wr(0, S_EN, 32'h0);

    // R10, R8: pin 79 = bank 2 bit 15, level high
    wr(2, S_T1, 32'h8000); wr(2, S_T0, 32'h8000); wr(2, S_EN, 32'h8000);
    pin_vec(79, 1'b1, v); strobe(v);
    rd(2, S_ST, d); chk("R8 bank2 bit15", d, 32'h8000);
    rd(0, S_ST, d); chk("R8 bank0 clear", d, 32'h0);
    rd(1, S_ST, d); chk("R8 bank1 clear", d, 32'h0);
    rd(3, S_ST, d); chk("R8 absent bank", d, 32'h0);
    wr(2, S_ST, 32'h8000);
    rd(2, S_ST, d); chk("R10 cleared until strobe", d, 32'h0);
    strobe(v);
    rd(2, S_ST, d); chk("R10 level re-sets", d, 32'h8000);
    // R13 clear and detection in one cycle
    reg_bank_i = 2'd2; reg_sel_i = S_ST; reg_wdata_i = 32'h8000; reg_we_i = 1'b1;
    sample_i = v; sample_vld_i = 1'b1;
    step();
    reg_we_i = 1'b0; sample_vld_i = 1'b0;
    rd(2, S_ST, d); chk("R13 set wins", d, 32'h8000);
    // R12 tail bits
    wr(2, S_EN, '1);
    rd(2, S_EN, d); chk("R12 tail enable", d, 32'h0000FFFF);
    wr(2, S_T2, '1);
    rd(2, S_T2, d); chk("R12 tail type2", d, 32'h0000FFFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule